// File: doc/BRIEF.md
# DRAM Die Temperature Poller

This block keeps a fresh reading of the DRAM die temperature on hand for the thermal control logic. A countdown timer schedules each poll. When it expires, the block raises a mode register read request toward the command path, with the register address fixed at 4, and holds it until the command path grants it. The register byte comes back on the data bus in the cycle after the grant. The block captures it there, takes the temperature field from its upper five bits, and presents that field as a band code together with a one-cycle valid strobe.

The interval before the next poll follows the reading just delivered. A band code below a configurable near-threshold code selects the slow interval, which is sized so that polls stay within the 50 ms limit under normal conditions. A band at or above that code selects a shorter, fast interval. The interval is counted from the capture, so a grant that arrives late pushes every later poll back by the same amount. After reset is released, the first poll starts after a short fixed delay, so a reading is available early.

Top module: `mr_temp_poller`

## Requirements
- R1: While reset is asserted, `mrr_req` and `temp_valid` are 0 and `temp_band` is 0.
- R2: After reset is released, `mrr_req` first goes high just after the (START_CYCLES+1)-th rising clock edge at which reset is inactive.
- R3: Once raised, `mrr_req` stays high until a rising edge at which `mrr_gnt` is 1, and `mrr_addr` equals 4 whenever `mrr_req` is high.
- R4: If the grant is taken at edge E, the block samples `mrr_rdata` at edge E+1. `temp_valid` is 1 for exactly the one cycle that follows E+1, and in that cycle `temp_band` equals bits [7:3] of the byte sampled at E+1.
- R5: `temp_band` changes only when `temp_valid` rises. Bits [2:0] of the returned byte, and `mrr_rdata` in every cycle other than the one after a grant, have no effect on it.
- R6: If the band just delivered is below NEAR_CODE and the valid strobe starts at edge T, the next request goes high at edge T+SLOW_CYCLES-2. With a grant in the same cycle, successive strobes are therefore SLOW_CYCLES apart.
- R7: If the band just delivered is at or above NEAR_CODE, the same timing holds with FAST_CYCLES in place of SLOW_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrr_req | output | 1 | Mode register read request to the command path |
| mrr_addr | output | ADDR_W | Mode register address of the request (4) |
| mrr_gnt | input | 1 | Grant from the command path; the read issues at this edge |
| mrr_rdata | input | DATA_W | Register byte returned on the data bus |
| temp_band | output | DATA_W-BAND_LSB | Captured temperature band code |
| temp_valid | output | 1 | One-cycle strobe marking a fresh band code |

## Verification
The bench uses a small configuration and steps through every one of the 256 returned byte values, in a scrambled order. Every byte is therefore captured, and the run separates correct field extraction from mistakes in the shift or the mask, including mistakes that show only in the low bits. The order also mixes bands on both sides of the near-threshold code, so each interval length follows both slow and fast readings and a swapped or stale interval choice shows up as a wrong request time. Grant delays of zero, one and two cycles, together with garbage driven on the data bus outside the capture cycle, separate a correct request hold and capture window from an off-by-one capture or a timer that restarts too early.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_REQ  = 2'd1,
        ST_CAPT = 2'd2
    } poll_st_e;

endpackage

// File: rtl/tpoll_timer.sv
module tpoll_timer #(
    parameter int CNT_W     = 8,
    parameter int START_VAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= CNT_W'(START_VAL);
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.cnt == '0);

    // R6 R7: without a reload the count never rises
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (tmr_q.cnt <= $past(tmr_q.cnt)));

endmodule

// File: rtl/tpoll_capture.sv
module tpoll_capture #(
    parameter int DATA_W    = 8,
    parameter int BAND_LSB  = 3,
    parameter int NEAR_CODE = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic [DATA_W-1:0]          rdata,
    output logic [DATA_W-BAND_LSB-1:0] band,
    output logic                       valid,
    output logic                       near
);

    localparam int BAND_W = DATA_W - BAND_LSB;

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic              valid;
    } cap_s;

    cap_s cap_d, cap_q;
    logic [BAND_W-1:0] field;

    assign field = rdata[DATA_W-1:BAND_LSB];
    assign near  = (int'(field) >= NEAR_CODE);

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = capture;
        if (capture) begin
            cap_d.band = field;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign band  = cap_q.band;
    assign valid = cap_q.valid;

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R5
    band_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(band));

endmodule

// File: rtl/mr_temp_poller.sv
module mr_temp_poller #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 8,
    parameter int MR_INDEX     = 4,
    parameter int BAND_LSB     = 3,
    parameter int SLOW_CYCLES  = 50_000_000,
    parameter int FAST_CYCLES  = 5_000_000,
    parameter int START_CYCLES = 16,
    parameter int NEAR_CODE    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic                       mrr_req,
    output logic [ADDR_W-1:0]          mrr_addr,
    input  logic                       mrr_gnt,
    input  logic [DATA_W-1:0]          mrr_rdata,
    output logic [DATA_W-BAND_LSB-1:0] temp_band,
    output logic                       temp_valid
);

    import tpoll_pkg::*;

    localparam int BAND_W  = DATA_W - BAND_LSB;
    localparam int MAX_A   = (SLOW_CYCLES > FAST_CYCLES) ? SLOW_CYCLES : FAST_CYCLES;
    localparam int CNT_MAX = (MAX_A > START_CYCLES) ? MAX_A : START_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    // the capture edge, the request edge and the grant edge use up three cycles
    localparam int SLOW_LD = SLOW_CYCLES - 3;
    localparam int FAST_LD = FAST_CYCLES - 3;

    typedef struct packed {
        poll_st_e st;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap_en;
    logic             band_near;
    logic [BAND_W-1:0] band_w;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_WAIT: if (tmr_expired) ctl_d.st = ST_REQ;
            ST_REQ:  if (mrr_gnt)     ctl_d.st = ST_CAPT;
            ST_CAPT: ctl_d.st = ST_WAIT;
            default: ctl_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st <= ST_WAIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mrr_req  = (ctl_q.st == ST_REQ);
    assign mrr_addr = ADDR_W'(MR_INDEX);
    assign cap_en   = (ctl_q.st == ST_CAPT);
    assign tmr_load = cap_en;
    assign tmr_val  = band_near ? CNT_W'(FAST_LD) : CNT_W'(SLOW_LD);

    tpoll_timer #(
        .CNT_W     (CNT_W),
        .START_VAL (START_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    tpoll_capture #(
        .DATA_W    (DATA_W),
        .BAND_LSB  (BAND_LSB),
        .NEAR_CODE (NEAR_CODE)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .rdata   (mrr_rdata),
        .band    (band_w),
        .valid   (temp_valid),
        .near    (band_near)
    );

    assign temp_band = band_w;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrr_req && !mrr_gnt) |=> mrr_req);

    // R4
    grant_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |-> $past(mrr_req && mrr_gnt, 2));

    // R6 R7: no new request in the strobe cycle
    no_req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |-> !mrr_req);

endmodule

// File: tb/mr_temp_poller_test.sv
module mr_temp_poller_test;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW  = 20;
    localparam int FAST  = 7;
    localparam int START = 5;
    localparam int NEAR  = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mrr_req;
    logic [7:0] mrr_addr;
    logic       mrr_gnt;
    logic [7:0] mrr_rdata;
    logic [4:0] temp_band;
    logic       temp_valid;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    mr_temp_poller #(
        .SLOW_CYCLES  (SLOW),
        .FAST_CYCLES  (FAST),
        .START_CYCLES (START),
        .NEAR_CODE    (NEAR)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrr_req    (mrr_req),
        .mrr_addr   (mrr_addr),
        .mrr_gnt    (mrr_gnt),
        .mrr_rdata  (mrr_rdata),
        .temp_band  (temp_band),
        .temp_valid (temp_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    initial begin
        int exp_req;
        int last_band;
        int tcap;
        rst_n = 1'b0;
        mrr_gnt = 1'b0;
        mrr_rdata = 8'h00;
        repeat (3) @(negedge clk);
        // R1
        check(mrr_req == 1'b0, "R1 req", int'(mrr_req), 0);
        check(temp_valid == 1'b0, "R1 valid", int'(temp_valid), 0);
        check(temp_band == 5'd0, "R1 band", int'(temp_band), 0);
        rst_n = 1'b1;
        last_band = 0;
        exp_req = START + 1;
        for (int i = 0; i < 256; i++) begin
            int value;
            int d;
            int guard;
            value = (i * 73 + 5) & 255;
            d = i % 3;
            guard = 0;
            while (mrr_req !== 1'b1 && guard < 1000) begin
                // R5: nothing moves between polls
                check(temp_valid == 1'b0, "R5 idle valid", int'(temp_valid), 0);
                check(int'(temp_band) == last_band, "R5 idle band", int'(temp_band), last_band);
                guard++;
                @(negedge clk);
            end
            if (i == 0)
                check(cyc == exp_req, "R2 first request", cyc, exp_req);
            else if (last_band >= NEAR)
                check(cyc == exp_req, "R7 fast interval", cyc, exp_req);
            else
                check(cyc == exp_req, "R6 slow interval", cyc, exp_req);
            // R3
            check(mrr_addr == 8'd4, "R3 address", int'(mrr_addr), 4);
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                check(mrr_req == 1'b1, "R3 request held", int'(mrr_req), 1);
            end
            mrr_gnt = 1'b1;
            @(negedge clk);
            mrr_gnt = 1'b0;
            mrr_rdata = 8'(value);
            check(temp_valid == 1'b0, "R4 no early valid", int'(temp_valid), 0);
            @(negedge clk);
            mrr_rdata = ~8'(value);
            check(temp_valid == 1'b1, "R4 valid", int'(temp_valid), 1);
            check(int'(temp_band) == (value >> 3), "R4 band field", int'(temp_band), value >> 3);
            tcap = cyc;
            last_band = value >> 3;
            @(negedge clk);
            check(temp_valid == 1'b0, "R4 single pulse", int'(temp_valid), 0);
            check(int'(temp_band) == last_band, "R5 band held", int'(temp_band), last_band);
            exp_req = tcap + ((last_band >= NEAR) ? FAST : SLOW) - 2;
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule